// File: doc/BRIEF.md
# Mask Error Rate Map Accumulator

This block runs a complete sweep of a rectangular sampling mask over a received eye and records, for every mask setting, how often data transitions fall inside the mask. For each setting it emits the vertical level and the early and late phase indices to an external controller, waits a fixed number of settle cycles, and then counts a divided error strobe over a window of 2^W bit-clock cycles. The count is turned into a mask error rate under the assumption that half of all bits carry a transition, and the rate is written into an internal map with one entry per mask.

While the sweep runs, the block tracks the effective eye opening. This is the largest mask, measured as (level+1)·(phase+1), whose rate does not exceed a threshold captured at start. After the sweep, the map can be read through a request/response stream. A request is accepted on a cycle where `rd_valid` and `rd_ready` are both high. The response appears on the following cycle and stays on `rsp_valid`/`rsp_rate` until `rsp_ready` is high. A new request is accepted only when no response is waiting or the waiting one is being taken in the same cycle.

Top module: `eye_mer_mapper`

## Requirements
- R1: A sweep starts only when `start` is high while `busy` is low. At that edge `win_log2`, `div_sel` and `thr` are captured. A `start` pulse or a change of these inputs during a sweep has no effect.
- R2: Masks are visited in index order idx = lvl·30 + side·15 + ph, with lvl 0..6, side 0..1 and ph 0..14. Side 0 drives `ph_early`=ph and `ph_late`=0. Side 1 drives `ph_early`=0 and `ph_late`=ph. `vlevel`=lvl.
- R3: Each mask starts with a one-cycle `mask_step` pulse on the first of 4 settle cycles. Then come exactly 2^W counting cycles, and then one cycle with `win_done` high.
- R4: Every counting cycle with `err_in` high adds one to a 16-bit counter that saturates at 65535. The counter is cleared during settle.
- R5: The stored rate is an unsigned fraction with 16 fraction bits: floor(cnt·4^div_sel·2·65536 / 2^W). The rate saturates at 0xFFFF.
- R6: The rate of each mask is written to map entry idx at the end of its `win_done` cycle. The map holds 210 entries.
- R7: A read request gets its response one cycle after acceptance, with the entry's value as it stood before that edge. A response is held unchanged while `rsp_ready` is low. `rd_ready` = !rsp_valid || rsp_ready.
- R8: A read of an address 210 or above returns 0.
- R9: The eye tracker is cleared at start. At each store whose rate ≤ captured threshold and whose score (lvl+1)·(ph+1) is strictly larger than the best so far, it sets `eye_found` and `eye_idx`=idx. On ties the earlier mask is kept.
- R10: `sweep_done` pulses for one cycle after the store of entry 209. The block is idle on the next cycle. The mask outputs keep their last value.
- R11: After reset the block is idle and `busy`, `mask_step`, `win_done`, `sweep_done`, `eye_found` and `rsp_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sweep request, honoured only while idle |
| win_log2 | input | 5 | Window length exponent W |
| div_sel | input | 2 | Error strobe divide ratio 4^div_sel |
| thr | input | 16 | Rate threshold for the eye opening |
| err_in | input | 1 | Divided mask error strobe |
| busy | output | 1 | Sweep in progress |
| mask_step | output | 1 | New mask setting applied |
| vlevel | output | 3 | Vertical level index |
| ph_early | output | 4 | Early sampling phase index |
| ph_late | output | 4 | Late sampling phase index |
| win_done | output | 1 | Window closed, rate being stored |
| sweep_done | output | 1 | Sweep finished |
| eye_found | output | 1 | A qualifying mask exists |
| eye_idx | output | 8 | Map index of the largest qualifying mask |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| rd_addr | input | 8 | Map index to read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rate | output | 16 | Stored rate |

## Verification
Several invariants are checked on every cycle by the assertions: the indices stay in range and agree with the running map index, `mask_step` is a single-cycle pulse, the error counter sticks at saturation and clears in settle, a waiting response stays stable under back-pressure, and the tracker is monotone. Other behaviour can only be shown by the bench scenarios, which compare against a behavioural model on every clock. These are the exact rate arithmetic across window lengths and divide ratios, saturation under a constant error strobe, the order of read and write on one edge, tie-breaking in the eye search, and the ignored mid-sweep restart and parameter change.

// File: rtl/eyemap_pkg.sv
package eyemap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_MEAS,
    ST_STORE,
    ST_DONE
  } seq_st_t;
endpackage

// File: rtl/map_seq.sv
module map_seq
  import eyemap_pkg::*;
#(
  parameter int NLVL   = 7,
  parameter int NPH    = 15,
  parameter int SETTLE = 4,
  parameter int WLOG_W = 5,
  localparam int ROW   = 2 * NPH,
  localparam int DEPTH = NLVL * ROW,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(NLVL),
  localparam int PW    = $clog2(NPH),
  localparam int TW    = 2 ** WLOG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WLOG_W-1:0] win_log2,
  output seq_st_t           st,
  output logic [LW-1:0]     lvl,
  output logic              side,
  output logic [PW-1:0]     ph,
  output logic [AW-1:0]     idx,
  output logic              step
);
  logic [TW-1:0]     tcnt;
  logic [WLOG_W-1:0] wlog;
  logic [TW-1:0]     win_end;
  logic              last;

  assign win_end = (TW'(1) << wlog) - TW'(1);
  assign last    = (idx == AW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      lvl  <= '0;
      side <= 1'b0;
      ph   <= '0;
      idx  <= '0;
      tcnt <= '0;
      wlog <= '0;
      step <= 1'b0;
    end else begin
      step <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st   <= ST_SETTLE;
            lvl  <= '0;
            side <= 1'b0;
            ph   <= '0;
            idx  <= '0;
            tcnt <= '0;
            wlog <= win_log2;
            step <= 1'b1;
          end
        end
        ST_SETTLE: begin
          if (tcnt == TW'(SETTLE - 1)) begin
            st   <= ST_MEAS;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_MEAS: begin
          if (tcnt == win_end) begin
            st   <= ST_STORE;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_STORE: begin
          if (last) begin
            st <= ST_DONE;
          end else begin
            st   <= ST_SETTLE;
            step <= 1'b1;
            idx  <= idx + 1'b1;
            if (ph == PW'(NPH - 1)) begin
              ph   <= '0;
              side <= ~side;
              if (side) lvl <= lvl + 1'b1;
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lvl) < NLVL) && (int'(ph) < NPH)); // R2
  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) == int'(lvl) * ROW + int'(side) * NPH + int'(ph)); // R2
  AST_STEP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step); // R3
  AST_STEP_AT_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (st == ST_SETTLE) && (tcnt == '0)); // R3
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |=> (st == ST_IDLE)); // R10
endmodule

// File: rtl/map_rate.sv
module map_rate #(
  parameter int CNT_W  = 16,
  parameter int RATE_W = 16,
  parameter int DIV_W  = 2,
  parameter int WLOG_W = 5,
  localparam int SHMAX = 2 * (2 ** DIV_W - 1) + 1 + RATE_W,
  localparam int WW    = CNT_W + SHMAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cnt_en,
  input  logic [DIV_W-1:0]  div,
  input  logic [WLOG_W-1:0] wlog,
  output logic [RATE_W-1:0] rate
);
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shamt;
  logic [WW-1:0]    wide;
  logic [WW-1:0]    scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (cnt_en && (cnt != '1))  cnt <= cnt + 1'b1;
  end

  always_comb begin
    shamt  = 8'({div, 1'b1}) + 8'(RATE_W);
    wide   = WW'(cnt) << shamt;
    scaled = wide >> wlog;
    rate   = (|scaled[WW-1:RATE_W]) ? '1 : scaled[RATE_W-1:0];
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && !clr) |=> (cnt == '1)); // R4
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !cnt_en) |=> $stable(cnt)); // R4
endmodule

// File: rtl/map_store.sv
module map_store #(
  parameter int DEPTH  = 210,
  parameter int RATE_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [RATE_W-1:0] wdata,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [AW-1:0]     rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RATE_W-1:0] rsp_rate
);
  logic [RATE_W-1:0] mem [DEPTH];
  logic              fire;

  assign rd_ready = !rsp_valid || rsp_ready;
  assign fire     = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rate  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rate  <= (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rate)); // R7
  AST_RSP_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid); // R7
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready); // R7
endmodule

// File: rtl/map_eye.sv
module map_eye #(
  parameter int LW     = 3,
  parameter int PW     = 4,
  parameter int AW     = 8,
  parameter int RATE_W = 16,
  localparam int SW    = LW + PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [RATE_W-1:0] rate,
  input  logic [RATE_W-1:0] thr,
  input  logic [LW-1:0]     lvl,
  input  logic [PW-1:0]     ph,
  input  logic [AW-1:0]     idx,
  output logic              found,
  output logic [AW-1:0]     best_idx
);
  logic [SW-1:0] score;
  logic [SW-1:0] best_score;
  logic          better;

  assign score  = (SW'(lvl) + SW'(1)) * (SW'(ph) + SW'(1));
  assign better = upd && (rate <= thr) && (!found || (score > best_score));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found      <= 1'b0;
      best_idx   <= '0;
      best_score <= '0;
    end else if (clr) begin
      found      <= 1'b0;
      best_idx   <= '0;
      best_score <= '0;
    end else if (better) begin
      found      <= 1'b1;
      best_idx   <= idx;
      best_score <= score;
    end
  end

  AST_EYE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !clr) |=> found); // R9
  AST_EYE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !clr) |=> (best_score >= $past(best_score))); // R9
  AST_EYE_QUALIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && upd && (rate <= thr) && !found) |=> found); // R9
endmodule

// File: rtl/eye_mer_mapper.sv
module eye_mer_mapper
  import eyemap_pkg::*;
#(
  parameter int NLVL   = 7,
  parameter int NPH    = 15,
  parameter int SETTLE = 4,
  parameter int WLOG_W = 5,
  parameter int DIV_W  = 2,
  parameter int CNT_W  = 16,
  parameter int RATE_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [WLOG_W-1:0]               win_log2,
  input  logic [DIV_W-1:0]                div_sel,
  input  logic [RATE_W-1:0]               thr,
  input  logic                            err_in,
  output logic                            busy,
  output logic                            mask_step,
  output logic [$clog2(NLVL)-1:0]         vlevel,
  output logic [$clog2(NPH)-1:0]          ph_early,
  output logic [$clog2(NPH)-1:0]          ph_late,
  output logic                            win_done,
  output logic                            sweep_done,
  output logic                            eye_found,
  output logic [$clog2(NLVL*2*NPH)-1:0]   eye_idx,
  input  logic                            rd_valid,
  output logic                            rd_ready,
  input  logic [$clog2(NLVL*2*NPH)-1:0]   rd_addr,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [RATE_W-1:0]               rsp_rate
);
  localparam int DEPTH = NLVL * 2 * NPH;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(NLVL);
  localparam int PW    = $clog2(NPH);

  seq_st_t           st;
  logic [LW-1:0]     lvl;
  logic              side;
  logic [PW-1:0]     ph;
  logic [AW-1:0]     idx;
  logic              step;
  logic [DIV_W-1:0]  div_lat;
  logic [RATE_W-1:0] thr_lat;
  logic [RATE_W-1:0] rate;
  logic [WLOG_W-1:0] wlog_lat;
  logic              launch;

  assign launch = start && (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lat  <= '0;
      thr_lat  <= '0;
      wlog_lat <= '0;
    end else if (launch) begin
      div_lat  <= div_sel;
      thr_lat  <= thr;
      wlog_lat <= win_log2;
    end
  end

  map_seq #(.NLVL(NLVL), .NPH(NPH), .SETTLE(SETTLE), .WLOG_W(WLOG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .win_log2(win_log2),
    .st(st), .lvl(lvl), .side(side), .ph(ph), .idx(idx), .step(step)
  );

  map_rate #(.CNT_W(CNT_W), .RATE_W(RATE_W), .DIV_W(DIV_W), .WLOG_W(WLOG_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_SETTLE),
    .cnt_en((st == ST_MEAS) && err_in), .div(div_lat), .wlog(wlog_lat),
    .rate(rate)
  );

  map_store #(.DEPTH(DEPTH), .RATE_W(RATE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st == ST_STORE), .waddr(idx), .wdata(rate),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rate(rsp_rate)
  );

  map_eye #(.LW(LW), .PW(PW), .AW(AW), .RATE_W(RATE_W)) u_eye (
    .clk(clk), .rst_n(rst_n), .clr(launch), .upd(st == ST_STORE),
    .rate(rate), .thr(thr_lat), .lvl(lvl), .ph(ph), .idx(idx),
    .found(eye_found), .best_idx(eye_idx)
  );

  assign busy       = (st != ST_IDLE);
  assign mask_step  = step;
  assign vlevel     = lvl;
  assign ph_early   = side ? '0 : ph;
  assign ph_late    = side ? ph : '0;
  assign win_done   = (st == ST_STORE);
  assign sweep_done = (st == ST_DONE);

  AST_SIDE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_early == '0) || (ph_late == '0)); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sweep_done) |=> busy); // R1
  AST_WIN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done); // R3
endmodule

// File: tb/sim_eye_mer_mapper.sv
module sim_eye_mer_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  win_log2 = '0;
  logic [1:0]  div_sel = '0;
  logic [15:0] thr = '0;
  logic        err_in = 1'b0;
  logic        busy, mask_step, win_done, sweep_done, eye_found;
  logic [2:0]  vlevel;
  logic [3:0]  ph_early, ph_late;
  logic [7:0]  eye_idx;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [7:0]  rd_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rate;

  int n_chk = 0;
  int n_err = 0;
  int err_mode = 0;
  bit bp_on = 0;
  int cycles = 0;

  // reference model state
  int ms = 0, mt = 0, midx = 0, mlvl = 0, mside = 0, mph = 0, mstep = 0;
  int mcnt = 0, mW = 0, mdiv = 0, mthr = 0;
  int mfound = 0, mbest = 0, mbscore = 0, mrv = 0, mrd = 0;
  int map [256];

  always #10 clk = ~clk;

  eye_mer_mapper u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .win_log2(win_log2),
    .div_sel(div_sel), .thr(thr), .err_in(err_in), .busy(busy),
    .mask_step(mask_step), .vlevel(vlevel), .ph_early(ph_early),
    .ph_late(ph_late), .win_done(win_done), .sweep_done(sweep_done),
    .eye_found(eye_found), .eye_idx(eye_idx), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rate(rsp_rate)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycles, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      longint r;
      int sc;
      int rdy;
      rdy = (!mrv || rsp_ready) ? 1 : 0;
      if (mrv && rsp_ready) mrv = 0;
      if (rd_valid && rdy) begin
        mrv = 1;
        mrd = (rd_addr < 210) ? map[rd_addr] : 0;
      end
      mstep = 0;
      case (ms)
        0: if (start) begin
          ms = 1; mt = 0; midx = 0; mlvl = 0; mside = 0; mph = 0;
          mW = win_log2; mdiv = div_sel; mthr = thr; mstep = 1;
          mfound = 0; mbest = 0; mbscore = 0;
        end
        1: begin
          mcnt = 0;
          if (mt == 3) begin ms = 2; mt = 0; end else mt++;
        end
        2: begin
          if (err_in && mcnt < 65535) mcnt++;
          if (mt == (1 << mW) - 1) begin ms = 3; mt = 0; end else mt++;
        end
        3: begin
          r = (longint'(mcnt) * (longint'(1) << (2 * mdiv)) * 2 * 65536) >> mW;
          if (r > 65535) r = 65535;
          map[midx] = int'(r);
          sc = (mlvl + 1) * (mph + 1);
          if (int'(r) <= mthr && (!mfound || sc > mbscore)) begin
            mfound = 1; mbest = midx; mbscore = sc;
          end
          if (midx == 209) ms = 4;
          else begin
            ms = 1; mstep = 1; midx++;
            if (mph == 14) begin
              mph = 0;
              if (mside == 1) mlvl++;
              mside = 1 - mside;
            end else mph++;
          end
        end
        default: ms = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
    end
    chk("R11/R1 busy", busy, ms != 0);
    chk("R3 mask_step", mask_step, mstep);
    chk("R3 win_done", win_done, ms == 3);
    chk("R10 sweep_done", sweep_done, ms == 4);
    chk("R2 vlevel", vlevel, mlvl);
    chk("R2 ph_early", ph_early, mside ? 0 : mph);
    chk("R2 ph_late", ph_late, mside ? mph : 0);
    chk("R9 eye_found", eye_found, mfound);
    chk("R9 eye_idx", eye_idx, mbest);
    chk("R7 rsp_valid", rsp_valid, mrv);
    chk("R7 rd_ready", rd_ready, (!mrv || rsp_ready) ? 1 : 0);
    if (mrv) chk("R5/R6/R8 rsp_rate", rsp_rate, mrd);
    case (err_mode)
      0: err_in = (($urandom % 64) < ((mlvl * 5 + mph * 3 + mside * 7) % 40));
      1: err_in = 1'b1;
      default: err_in = 1'b0;
    endcase
    rsp_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
  end

  task automatic sweep(input int w, input int d, input int t, input int mode, input bit poke);
    @(negedge clk);
    err_mode = mode;
    win_log2 = 5'(w); div_sel = 2'(d); thr = 16'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R1: restart and parameter change during a sweep must be ignored
      repeat (50) @(negedge clk);
      start = 1'b1; win_log2 = 5'(w + 2); thr = 16'hFFFF; div_sel = 2'(d + 1);
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  task automatic read_one(input int a);
    rd_valid = 1'b1;
    rd_addr = 8'(a);
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic read_all();
    for (int a = 0; a < 210; a++) read_one(a);
    read_one(220); // R8 out of range
    read_one(255); // R8 out of range
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) map[i] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 eye_found", eye_found, 0);
    chk("R11 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sweep(3, 0, 16'h2000, 0, 1);
    bp_on = 1;
    read_all();
    sweep(5, 2, 16'h4000, 0, 0);
    read_all();
    // R5 saturation under constant error strobe
    bp_on = 0;
    sweep(2, 1, 16'hFFFF, 1, 0);
    read_one(17);
    chk("R5 saturated rate", rsp_rate, 16'hFFFF);
    chk("R9 all masks qualify", eye_idx, 194);
    // R9 zero rate, tie between idx 194 and 209 keeps 194
    sweep(4, 3, 0, 2, 0);
    chk("R9 tie keeps earlier", eye_idx, 194);
    chk("R9 found at zero thr", eye_found, 1);
    bp_on = 1;
    read_all();
    finish_run();
  end
endmodule